// File: doc/BRIEF.md
# Dual-Channel Serial Converter Command Front End

This block is the digital side of a two-channel 12-bit converter. A host writes 16-bit command words over a three-wire serial link made of an active-low select, a serial clock and a data line. The top four bits of each word are control bits. The lower twelve bits are a channel code. The control bits decide where the code lands: channel A, channel B, or a shadow register. Writing through the shadow register lets the host stage a new channel-B value and then move both channels in the same cycle. The same word also sets a speed-mode flag and a power-down flag for the analog stage.

The serial pins are asynchronous to the block. Each one goes through a two-flop synchronizer, and all edges are found in the system clock domain. A mode input picks how a frame ends. In external framing, the rising edge of select ends it. In counted framing, the frame ends by itself after sixteen serial clock falls, and an earlier rise of select also ends it. A status output reports whether the last frame that ended held fewer than sixteen bits.

Top module: `dual_dac_serial_if`

## Requirements
- R1: While select is low, each falling edge of the serial clock shifts the data line into a 16-bit register, most significant bit first. Serial clock edges while select is high leave that register untouched.
- R2: In the word, bits 15..12 are control bits and bits 11..0 are the channel code, with bit 11 as the code MSB.
- R3: A word with bit 15 = 1 loads its code into channel A and copies the shadow register into channel B in the same cycle. The shadow register itself does not change.
- R4: A word with bit 15 = 0 and bit 12 = 0 loads its code into both channel B and the shadow register. Channel A does not change.
- R5: A word with bit 15 = 0 and bit 12 = 1 loads its code into the shadow register only. Both channel outputs stay as they were.
- R6: Each word that takes effect sets the fast flag from bit 14 (1 = fast, 0 = slow) and the power-down flag from bit 13 (1 = powered down, 0 = operating).
- R7: The outputs change only when a frame ends. Bits shifted while select is still low do not move any output.
- R8: With the counted mode input at 1, the frame takes effect once the sixteenth serial clock fall has been shifted, while select is still low. Further clock falls are ignored until select falls again, and the later rise of select causes no second update.
- R9: In counted mode, a rise of select before sixteen bits ends the frame early. The transfer uses whatever the shift register holds at that point.
- R10: After reset, both channel codes, the shadow register, the fast flag, the power-down flag and the short-frame flag are all 0.
- R11: A frame that ends after fewer than 16 bits (including zero bits) still decodes the current shift-register contents. It sets the short-frame flag to 1. A full 16-bit frame clears that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_frame | input | 1 | 1 = counted framing, 0 = framing by select |
| sel_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdin | input | 1 | Serial data, asynchronous |
| code_a | output | 12 | Channel A code |
| code_b | output | 12 | Channel B code |
| fast_mode | output | 1 | Speed-mode flag |
| power_down | output | 1 | Power-down flag |
| short_frame | output | 1 | Last frame held fewer than 16 bits |

## Verification
The assertions rely on these conditions:
- Every level of the serial clock lasts longer than the synchronizer depth plus one system cycle.
- Data is stable across each serial clock fall.
- At least one system cycle passes between a select fall and the first serial clock fall.
- At least one system cycle passes between the last serial clock fall and the select rise.

Under those conditions the synchronized edges keep the same order they had at the pins. The stimulus holds each serial clock level and each select gap for four system cycles. It changes the data line only while the serial clock is high. The auto_frame input changes only while select is idle high.

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if #(
  parameter int CODE_W      = 12,
  parameter int PROG_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_frame,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              fast_mode,
  output logic              power_down,
  output logic              short_frame
);
  localparam int WORD_W = CODE_W + PROG_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int B_ROUTE = WORD_W - 1;
  localparam int B_SPEED = WORD_W - 2;
  localparam int B_PDOWN = WORD_W - 3;
  localparam int B_SHONLY = WORD_W - 4;

  logic [SYNC_STAGES:0] sel_p, clk_p, dat_p;
  logic [WORD_W-1:0]    sr;
  logic [CODE_W-1:0]    shadow;
  logic [CNT_W-1:0]     bit_cnt;
  logic                 open_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_p <= '1;
      clk_p <= '1;
      dat_p <= '0;
    end else begin
      sel_p <= {sel_p[SYNC_STAGES-1:0], sel_n};
      clk_p <= {clk_p[SYNC_STAGES-1:0], sclk};
      dat_p <= {dat_p[SYNC_STAGES-1:0], sdin};
    end

  wire sel_s     = sel_p[SYNC_STAGES-1];
  wire sel_fall  = sel_p[SYNC_STAGES] & ~sel_s;
  wire sel_rise  = ~sel_p[SYNC_STAGES] & sel_s;
  wire sclk_fall = clk_p[SYNC_STAGES] & ~clk_p[SYNC_STAGES-1];
  wire din       = dat_p[SYNC_STAGES-1];
  wire full      = (bit_cnt == CNT_W'(WORD_W));
  wire shift_en  = open_q & ~sel_s & sclk_fall & ~(auto_frame & full);
  wire commit    = open_q & (sel_rise | (auto_frame & full));
  wire [CODE_W-1:0] payload = sr[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      open_q  <= 1'b0;
      bit_cnt <= '0;
      sr      <= '0;
    end else begin
      if (sel_fall)    open_q <= 1'b1;
      else if (commit) open_q <= 1'b0;
      if (sel_fall)              bit_cnt <= '0;
      else if (shift_en && !full) bit_cnt <= bit_cnt + 1'b1;
      if (shift_en) sr <= {sr[WORD_W-2:0], din};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      code_a      <= '0;
      code_b      <= '0;
      shadow      <= '0;
      fast_mode   <= 1'b0;
      power_down  <= 1'b0;
      short_frame <= 1'b0;
    end else if (commit) begin
      fast_mode   <= sr[B_SPEED];
      power_down  <= sr[B_PDOWN];
      short_frame <= ~full;
      if (sr[B_ROUTE]) begin
        code_a <= payload;
        code_b <= shadow;
      end else begin
        shadow <= payload;
        if (!sr[B_SHONLY]) code_b <= payload;
      end
    end

  p_sel_high_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> $stable(sr));
  p_copy_shadow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit && sr[B_ROUTE] |=> code_b == $past(shadow) && $stable(shadow));
  p_b_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !sr[B_ROUTE] && !sr[B_SHONLY] |=> code_b == shadow && $stable(code_a));
  p_shadow_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !sr[B_ROUTE] && sr[B_SHONLY] |=> $stable(code_a) && $stable(code_b));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(code_a) && $stable(code_b) && $stable(fast_mode) && $stable(power_down));
  p_auto_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    auto_frame && open_q && full && !sel_fall |=> !open_q);
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W));
endmodule

// File: tb/dual_dac_serial_if_bench.sv
`timescale 1ns/1ps
module dual_dac_serial_if_bench;
  logic clk = 1'b0, rst_n = 1'b0, auto_frame = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b1, sdin = 1'b0;
  logic [11:0] code_a, code_b;
  logic fast_mode, power_down, short_frame;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_dac_serial_if u_dual_dac_serial_if (
    .clk(clk), .rst_n(rst_n), .auto_frame(auto_frame), .sel_n(sel_n),
    .sclk(sclk), .sdin(sdin), .code_a(code_a), .code_b(code_b),
    .fast_mode(fast_mode), .power_down(power_down), .short_frame(short_frame));

  // word, expected A, expected B, fast, power-down (external framing, applied in order)
  localparam logic [41:0] VEC [9] = '{
    {16'h4FFF, 12'h000, 12'hFFF, 1'b1, 1'b0},  // R4 R6
    {16'h9800, 12'h800, 12'hFFF, 1'b0, 1'b0},  // R3
    {16'h5123, 12'h800, 12'hFFF, 1'b1, 1'b0},  // R5
    {16'hE456, 12'h456, 12'h123, 1'b1, 1'b1},  // R3 R6
    {16'h2ABC, 12'h456, 12'hABC, 1'b0, 1'b1},  // R4
    {16'h8001, 12'h001, 12'hABC, 1'b0, 1'b0},  // R3 R2
    {16'h1777, 12'h001, 12'hABC, 1'b0, 1'b0},  // R5
    {16'h1555, 12'h001, 12'hABC, 1'b0, 1'b0},  // R5
    {16'hC000, 12'h000, 12'h555, 1'b1, 1'b0}   // R3
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      sdin = w[n-1-i];
      wait_cyc(4);
      sclk = 1'b0;
      wait_cyc(4);
      sclk = 1'b1;
    end
  endtask

  task automatic check(input string tag, input logic [26:0] act, input logic [26:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [26:0] outs();
    return {code_a, code_b, fast_mode, power_down, short_frame};
  endfunction

  task automatic ext_frame(input logic [15:0] w, input int n);
    sel_n = 1'b0; wait_cyc(4);
    shift_bits(w, n);
    wait_cyc(2);
    sel_n = 1'b1; wait_cyc(10);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    check("R10 reset", outs(), 27'd0);
    rst_n = 1'b1;
    wait_cyc(4);

    // R7: all 16 bits shifted, select still low
    sel_n = 1'b0; wait_cyc(4);
    shift_bits(VEC[0][41:26], 16);
    wait_cyc(10);
    check("R7 before select rise", outs(), 27'd0);
    sel_n = 1'b1; wait_cyc(10);
    check("R2,R4,R6 row 0", outs(), {VEC[0][25:0], 1'b0});

    for (int k = 1; k < 9; k++) begin
      ext_frame(VEC[k][41:26], 16);
      check($sformatf("R2,R3,R4,R5,R6 row %0d", k), outs(), {VEC[k][25:0], 1'b0});
    end

    // R1: clocks with select high must not shift; zero-bit frame re-applies 0xC000 (R11)
    shift_bits(16'h00FF, 8);
    wait_cyc(4);
    ext_frame(16'h0000, 0);
    check("R1,R11 idle clocks ignored", outs(), {12'h000, 12'h555, 1'b1, 1'b0, 1'b1});

    // R11: 8-bit frame -> register 0x0012 -> channel B and shadow get 0x012
    ext_frame(16'h0012, 8);
    check("R11 short frame", outs(), {12'h000, 12'h012, 1'b0, 1'b0, 1'b1});

    // R8: counted framing
    auto_frame = 1'b1; wait_cyc(4);
    sel_n = 1'b0; wait_cyc(4);
    shift_bits(16'h8ABC, 16);
    wait_cyc(10);
    check("R8 self close with select low", outs(), {12'hABC, 12'h012, 1'b0, 1'b0, 1'b0});
    shift_bits(16'h000F, 4);
    wait_cyc(2);
    sel_n = 1'b1; wait_cyc(10);
    check("R8 extra clocks and late rise ignored", outs(), {12'hABC, 12'h012, 1'b0, 1'b0, 1'b0});

    sel_n = 1'b0; wait_cyc(4);
    shift_bits(16'h0333, 16);
    wait_cyc(10);
    check("R8 second counted frame", outs(), {12'hABC, 12'h333, 1'b0, 1'b0, 1'b0});
    sel_n = 1'b1; wait_cyc(10);

    // R9: early rise after 8 bits -> register 0x3380 -> shadow only, power-down set
    ext_frame(16'h0080, 8);
    check("R9 early end", outs(), {12'hABC, 12'h333, 1'b0, 1'b1, 1'b1});
    ext_frame(16'h8000, 16);
    check("R9,R3 shadow from early frame", outs(), {12'h000, 12'h380, 1'b0, 1'b0, 1'b0});

    // R10: reset mid-run clears everything
    rst_n = 1'b0; wait_cyc(2);
    check("R10 reset again", outs(), 27'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule